// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-State Sequencer

This block sits between a memory scheduler and a DDR2 SDRAM. It owns the clock-enable pin and, while the device moves into or out of a low-power state, the chip-select/row/column/write-enable command lines. It follows the device through four conditions: awake with banks open, awake with all banks idle, power-down and self refresh. Power-down is reported as active or precharge power-down depending on whether any bank was open at entry. The scheduler asks for a transition with a request word. The block checks that the request is legal in the current state. It then lowers or raises CKE together with the one command the device must see on that edge: NOP on power-down entry and on any exit, REFRESH on self-refresh entry.

Requests use a valid/ready handshake. The scheduler raises `req_valid` with an opcode on `req_op` (0 power-down, 1 self refresh, 2 wake, 3 reserved) and must hold both stable until `req_ready` is high at a rising edge. `req_ready` is held low while CKE has not yet been at its current level for the minimum hold time. It is also low while the device is awake but normal commands are not yet allowed. An illegal request that is accepted is answered with a one-cycle `req_err` pulse and changes nothing.

After a wake, `ready_cmd` and `ready_read` tell the scheduler when it may again drive ordinary commands and READs. A power-down duration counter raises `force_exit` so that the scheduler wakes the device before a refresh would be missed. `odt_hold` tells the termination logic to keep ODT at a fixed level during power-down.

Top module: `cke_power_seq`

## Requirements
- R1: After reset, cke is 1, cmd_n is DESELECT (4'b1111, bit order cs_n, ras_n, cas_n, we_n), pwr_state reads 1 (idle) with banks_open low, and ready_cmd, ready_read and req_ready are all 1.
- R2: A power-down request (req_op 0) accepted while awake and not busy drives cke to 0 with cmd_n NOP (4'b0111) in the next cycle. pwr_state becomes 2 if banks_open was high at acceptance and 3 otherwise. cmd_n returns to DESELECT one cycle later.
- R3: A self-refresh request (req_op 1) accepted while awake, not busy and with no bank open drives cke to 0 with cmd_n REFRESH (4'b0001), and pwr_state becomes 4.
- R4: An accepted request that is illegal in the current state produces req_err high in the next cycle for exactly one cycle, and leaves cke and pwr_state unchanged. Illegal requests are: self refresh with a bank open, any entry while op_busy, wake while awake, any entry while already in a low-power state, and req_op 3.
- R5: req_ready stays low until cke has held its level for TCKE (3) cycles. A power-down entered and immediately followed by a wake request keeps cke low for exactly 3 cycles, and after a wake req_ready is low in the cycle that follows the exit cycle.
- R6: A wake request (req_op 2) accepted in power-down or self refresh drives cke to 1 with cmd_n NOP in the next cycle, then DESELECT. After a power-down exit, ready_cmd is low in the exit cycle and high in the cycle after.
- R7: After a self-refresh exit, ready_cmd first reads 1 exactly T_XSNR (24) cycles after the cycle in which cke became 1. In the meantime cmd_n stays DESELECT and req_ready stays low.
- R8: After a self-refresh exit, ready_read first reads 1 exactly T_XSRD (200) cycles after the cycle in which cke became 1.
- R9: force_exit rises exactly PD_LIMIT (2000) cycles after the first power-down cycle, stays high while in power-down, and is low in the exit cycle.
- R10: odt_hold is 1 in both power-down states and 0 when awake or in self refresh.
- R11: A request whose req_valid is held while req_ready is low is accepted at the first rising edge where req_ready is high, and takes effect then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transition request present |
| req_op | input | 2 | 0 power-down, 1 self refresh, 2 wake, 3 reserved |
| req_ready | output | 1 | Request will be taken at this edge |
| banks_open | input | 1 | At least one bank is active |
| op_busy | input | 1 | A read, write, mode load or precharge is still in progress |
| cke | output | 1 | Clock enable to the device |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} driven by this block |
| pwr_state | output | 3 | 0 active, 1 idle, 2 active power-down, 3 precharge power-down, 4 self refresh |
| ready_cmd | output | 1 | Scheduler may drive normal commands |
| ready_read | output | 1 | Scheduler may issue READ |
| force_exit | output | 1 | Power-down has lasted the refresh-safe limit; wake now |
| odt_hold | output | 1 | Keep ODT at a fixed level (power-down) |
| req_err | output | 1 | One-cycle pulse: the last accepted request was illegal |

## Verification
The embedded properties watch, on every cycle, that each CKE change lands only after the minimum hold. They also check that CKE falls only alongside NOP or REFRESH and rises only alongside NOP, that self refresh is entered only from an idle bank state, and that an error pulse never coincides with a state change. The directed scenarios are needed for the exact counts: the lengths of the two post-self-refresh windows, the cycle at which force_exit rises, which power-down flavour is reported, and the way back-pressure delays a held request.

// File: rtl/cke_pkg.sv
package cke_pkg;
  typedef enum logic [1:0] {M_AWAKE, M_PDN_ACT, M_PDN_PRE, M_SREF} mode_t;
  typedef enum logic [1:0] {OP_PDN = 2'd0, OP_SREF = 2'd1, OP_WAKE = 2'd2, OP_RSVD = 2'd3} op_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_REF   = 4'b0001;

  localparam logic [2:0] PS_ACTIVE  = 3'd0;
  localparam logic [2:0] PS_IDLE    = 3'd1;
  localparam logic [2:0] PS_PDN_ACT = 3'd2;
  localparam logic [2:0] PS_PDN_PRE = 3'd3;
  localparam logic [2:0] PS_SREF    = 3'd4;
endpackage

// File: rtl/cke_hold_timer.sv
module cke_hold_timer #(
  parameter int TCKE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_i,
  output logic hold_ok
);
  localparam int CW = (TCKE > 2) ? $clog2(TCKE) : 1;
  localparam logic [CW-1:0] SAT = CW'(TCKE - 2);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= SAT;
    end else begin
      prev_q <= cke_i;
      if (cke_i != prev_q)  cnt_q <= '0;
      else if (cnt_q < SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hold_ok = (cke_i == prev_q) && (cnt_q >= SAT);

  // R5
  cke_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i != prev_q) |-> $past(hold_ok));
endmodule

// File: rtl/cke_exit_window.sv
module cke_exit_window #(
  parameter int T_XSNR = 24,
  parameter int T_XSRD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cmd_ok,
  output logic read_ok
);
  localparam int CW = $clog2(T_XSRD + 1);
  localparam logic [CW-1:0] LIM_CMD  = CW'(T_XSNR);
  localparam logic [CW-1:0] LIM_READ = CW'(T_XSRD);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LIM_READ) run_q <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cmd_ok  = !run_q || (cnt_q >= LIM_CMD);
  assign read_ok = !run_q || (cnt_q >= LIM_READ);
endmodule

// File: rtl/cke_pd_watchdog.sv
module cke_pd_watchdog #(
  parameter int PD_LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pd,
  output logic force_o
);
  localparam int CW = $clog2(PD_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(PD_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!in_pd)      cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign force_o = in_pd && (cnt_q >= LIM);
endmodule

// File: rtl/cke_power_seq.sv
module cke_power_seq
  import cke_pkg::*;
#(
  parameter int TCKE     = 3,
  parameter int T_XSNR   = 24,
  parameter int T_XSRD   = 200,
  parameter int PD_LIMIT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  output logic       req_ready,
  input  logic       banks_open,
  input  logic       op_busy,
  output logic       cke,
  output logic [3:0] cmd_n,
  output logic [2:0] pwr_state,
  output logic       ready_cmd,
  output logic       ready_read,
  output logic       force_exit,
  output logic       odt_hold,
  output logic       req_err
);
  mode_t      mode_q;
  logic       cke_q, nop_q, err_q;
  logic [3:0] cmd_q;
  logic       hold_ok, win_cmd_ok, win_read_ok, in_pd, awake;
  logic       accept, legal, sr_exit;
  op_t        op;

  assign op     = op_t'(req_op);
  assign awake  = (mode_q == M_AWAKE);
  assign in_pd  = (mode_q == M_PDN_ACT) || (mode_q == M_PDN_PRE);
  assign accept = req_valid && req_ready;

  always_comb begin
    unique case (op)
      OP_PDN:  legal = awake && !op_busy;
      OP_SREF: legal = awake && !op_busy && !banks_open;
      OP_WAKE: legal = !awake;
      default: legal = 1'b0;
    endcase
  end

  assign sr_exit = accept && legal && (op == OP_WAKE) && (mode_q == M_SREF);

  cke_hold_timer #(.TCKE(TCKE)) i_hold (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_q), .hold_ok(hold_ok));

  cke_exit_window #(.T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) i_win (
    .clk(clk), .rst_n(rst_n), .start(sr_exit),
    .cmd_ok(win_cmd_ok), .read_ok(win_read_ok));

  cke_pd_watchdog #(.PD_LIMIT(PD_LIMIT)) i_wd (
    .clk(clk), .rst_n(rst_n), .in_pd(in_pd), .force_o(force_exit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_AWAKE;
      cke_q  <= 1'b1;
      cmd_q  <= CMD_DESEL;
      nop_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cmd_q <= CMD_DESEL;
      nop_q <= 1'b0;
      err_q <= accept && !legal;
      if (accept && legal) begin
        nop_q <= 1'b1;
        unique case (op)
          OP_PDN: begin
            mode_q <= banks_open ? M_PDN_ACT : M_PDN_PRE;
            cke_q  <= 1'b0;
            cmd_q  <= CMD_NOP;
          end
          OP_SREF: begin
            mode_q <= M_SREF;
            cke_q  <= 1'b0;
            cmd_q  <= CMD_REF;
          end
          default: begin
            mode_q <= M_AWAKE;
            cke_q  <= 1'b1;
            cmd_q  <= CMD_NOP;
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      M_PDN_ACT: pwr_state = PS_PDN_ACT;
      M_PDN_PRE: pwr_state = PS_PDN_PRE;
      M_SREF:    pwr_state = PS_SREF;
      default:   pwr_state = banks_open ? PS_ACTIVE : PS_IDLE;
    endcase
  end

  assign cke        = cke_q;
  assign cmd_n      = cmd_q;
  assign req_err    = err_q;
  assign odt_hold   = in_pd;
  assign ready_cmd  = awake && !nop_q && win_cmd_ok;
  assign ready_read = awake && !nop_q && win_read_ok;
  assign req_ready  = hold_ok && (!awake || ready_cmd);

  // R2
  cke_fall_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_q) |-> (cmd_q == CMD_NOP || cmd_q == CMD_REF));

  // R6
  cke_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |-> (cmd_q == CMD_NOP));

  // R3
  sref_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SREF && $past(mode_q) != M_SREF) |-> !$past(banks_open));

  // R4
  err_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mode_q == $past(mode_q) && cke_q == $past(cke_q)));
endmodule

// File: tb/test_cke_power_seq.sv
`timescale 1ns/1ps
module test_cke_power_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic       banks_open = 1'b0;
  logic       op_busy = 1'b0;
  logic       req_ready, cke, ready_cmd, ready_read, force_exit, odt_hold, req_err;
  logic [3:0] cmd_n;
  logic [2:0] pwr_state;

  int n_chk = 0;
  int n_bad = 0;

  localparam int XSNR = 24;
  localparam int XSRD = 200;
  localparam int PDL  = 2000;

  always #2 clk = ~clk;

  cke_power_seq i_cke_power_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .banks_open(banks_open), .op_busy(op_busy),
    .cke(cke), .cmd_n(cmd_n), .pwr_state(pwr_state), .ready_cmd(ready_cmd),
    .ready_read(ready_read), .force_exit(force_exit), .odt_hold(odt_hold),
    .req_err(req_err));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue request at a negedge; returns number of negedges waited for ready
  task automatic request(input logic [1:0] op, output int waited);
    waited = 0;
    req_valid = 1'b1;
    req_op    = op;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cke", cke, 1);
    chk("R1 cmd", cmd_n, 4'b1111);
    chk("R1 state", pwr_state, 1);
    chk("R1 ready_cmd", ready_cmd, 1);
    chk("R1 ready_read", ready_read, 1);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_pd_precharge;
    int w;
    banks_open = 1'b0;
    request(2'd0, w);
    chk("R2 cke low", cke, 0);
    chk("R2 nop", cmd_n, 4'b0111);
    chk("R2 pre state", pwr_state, 3);
    chk("R10 odt pd", odt_hold, 1);
    chk("R6 ready_cmd in pd", ready_cmd, 0);
    @(negedge clk);
    chk("R2 deselect", cmd_n, 4'b1111);
    request(2'd2, w);
    chk("R5 low hold", 2 + w, 3);
    chk("R6 cke high", cke, 1);
    chk("R6 nop", cmd_n, 4'b0111);
    chk("R6 ready_cmd exit cycle", ready_cmd, 0);
    chk("R10 odt awake", odt_hold, 0);
    @(negedge clk);
    chk("R6 ready_cmd after", ready_cmd, 1);
    chk("R6 deselect", cmd_n, 4'b1111);
    chk("R5 req_ready held off", req_ready, 0);
    @(negedge clk);
    chk("R5 req_ready", req_ready, 1);
  endtask

  task automatic t_pd_active_and_reject;
    int w;
    banks_open = 1'b1;
    request(2'd0, w);
    chk("R2 act state", pwr_state, 2);
    chk("R2 cke", cke, 0);
    request(2'd1, w);
    chk("R4 reentry err", req_err, 1);
    chk("R4 reentry state", pwr_state, 2);
    chk("R4 reentry cke", cke, 0);
    @(negedge clk);
    chk("R4 err one cycle", req_err, 0);
    request(2'd2, w);
    chk("R6 wake state", pwr_state, 0);
    settle(3);
  endtask

  task automatic t_errors;
    int w;
    banks_open = 1'b1;
    request(2'd1, w);
    chk("R4 sr banks open err", req_err, 1);
    chk("R4 sr banks open state", pwr_state, 0);
    chk("R4 sr banks open cke", cke, 1);
    @(negedge clk);
    chk("R4 pulse", req_err, 0);
    banks_open = 1'b0;
    op_busy = 1'b1;
    request(2'd0, w);
    chk("R4 busy err", req_err, 1);
    chk("R4 busy cke", cke, 1);
    op_busy = 1'b0;
    request(2'd2, w);
    chk("R4 wake awake err", req_err, 1);
    chk("R4 wake awake state", pwr_state, 1);
    request(2'd3, w);
    chk("R4 reserved err", req_err, 1);
    chk("R4 reserved cke", cke, 1);
    @(negedge clk);
    chk("R4 clear", req_err, 0);
  endtask

  task automatic t_self_refresh;
    int w, k;
    bit bad_cmd, bad_rdy;
    banks_open = 1'b0;
    request(2'd1, w);
    chk("R3 cke", cke, 0);
    chk("R3 refresh", cmd_n, 4'b0001);
    chk("R3 state", pwr_state, 4);
    chk("R10 odt sr", odt_hold, 0);
    settle(5);
    request(2'd2, w);
    chk("R6 sr exit cke", cke, 1);
    chk("R6 sr exit nop", cmd_n, 4'b0111);
    k = 0; bad_cmd = 0; bad_rdy = 0;
    while (!ready_cmd) begin
      @(negedge clk);
      k++;
      if (!ready_cmd && cmd_n != 4'b1111) bad_cmd = 1;
      if (!ready_cmd && req_ready) bad_rdy = 1;
    end
    chk("R7 xsnr window", k, XSNR);
    chk("R7 deselect in window", bad_cmd, 0);
    chk("R7 req_ready low in window", bad_rdy, 0);
    while (!ready_read) begin
      @(negedge clk);
      k++;
    end
    chk("R8 read window", k, XSRD);
  endtask

  task automatic t_force_and_backpressure;
    int w, k;
    banks_open = 1'b0;
    request(2'd0, w);
    k = 0;
    while (!force_exit) begin
      @(negedge clk);
      k++;
    end
    chk("R9 force cycle", k, PDL);
    settle(3);
    chk("R9 force held", force_exit, 1);
    request(2'd2, w);
    chk("R9 force clear", force_exit, 0);
    // back-pressure: ask again right away
    request(2'd0, w);
    chk("R11 waited", w, 2);
    chk("R11 accepted late", pwr_state, 3);
    request(2'd2, w);
    settle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pd_precharge();
    t_pd_active_and_reject();
    t_errors();
    t_self_refresh();
    t_force_and_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule